// File: doc/BRIEF.md
# Skip-Branch Next-Address Unit

This block owns the instruction address register of a word-addressed, single-cycle processor and picks the next address on every clock edge. Because each memory word is one instruction, straight-line code steps the address by one. The two conditional branch kinds do not have a target. Each one compares a register operand with a zero-extended 16-bit constant, and when the condition is met the unit steps by two, so the following instruction is skipped. An absolute jump loads the address register with the full register operand.

The decoder drives a two-bit branch code, a jump flag, the register operand and the immediate. The unit returns the address of the instruction now executing, and it also shows the address it will load on the next edge. Every kind of instruction completes in one cycle. All arithmetic wraps modulo the width of the address register.

Top module: `skip_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 on that edge.
- R2: When `jump` is low and `br_kind` is 2'b00 (plain step) or 2'b11 (reserved, treated as a plain step), `pc` advances by 1 on the next edge.
- R3: When `br_kind` is 2'b01 (skip-if-equal) and `jump` is low, `pc` advances by 2 if `reg_val` equals `imm` zero-extended to 32 bits, and by 1 otherwise.
- R4: When `br_kind` is 2'b10 (skip-if-not-equal) and `jump` is low, `pc` advances by 2 if `reg_val` differs from `imm` zero-extended to 32 bits, and by 1 otherwise.
- R5: When `jump` is high, `pc` is loaded with `reg_val` on the next edge, whatever the value of `br_kind`.
- R6: The upper 16 bits of `reg_val` take part in the comparison, so a nonzero upper half never equals the immediate.
- R7: Address arithmetic wraps modulo 2^WIDTH. For example, 32'hFFFFFFFF plus 2 is 32'h00000001.
- R8: `pc_next` always shows the value that `pc` will take on the next edge when `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_kind | input | 2 | 00 step, 01 skip-if-equal, 10 skip-if-not-equal, 11 step |
| jump | input | 1 | Absolute jump to reg_val |
| reg_val | input | WIDTH | Register operand |
| imm | input | 16 | Unsigned immediate |
| pc | output | WIDTH | Current instruction address |
| pc_next | output | WIDTH | Address loaded on the next edge |

## Verification
The assertions check the edge-to-edge relation on every cycle: the address moves by one, moves by two, or equals the jump operand, and the previous `pc_next` always matches the new `pc`. They cannot show that the step taken is the right one for a given comparison. The bench covers that with sweeps across all branch codes, with equal and unequal operands, with upper-half-only differences, and with operands near the wrap point. In each case it computes the expected address arithmetically.

// File: rtl/skip_pc_unit.sv
module skip_pc_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       br_kind,
  input  logic             jump,
  input  logic [WIDTH-1:0] reg_val,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] pc,
  output logic [WIDTH-1:0] pc_next
);
  localparam logic [1:0] K_EQ = 2'b01;
  localparam logic [1:0] K_NE = 2'b10;

  logic [WIDTH-1:0] imm_ext;
  logic             same;
  logic             skip;

  assign imm_ext = {{(WIDTH-IMM_W){1'b0}}, imm};
  assign same    = (reg_val == imm_ext);
  assign skip    = ((br_kind == K_EQ) && same) || ((br_kind == K_NE) && !same);
  assign pc_next = jump ? reg_val : (pc + (skip ? WIDTH'(2) : WIDTH'(1)));

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc == '0); // R1
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc == $past(reg_val)); // R5
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (!jump && seen) |=> (pc - $past(pc) == WIDTH'(1) || pc - $past(pc) == WIDTH'(2))); // R7
  AST_PLAIN_ONE: assert property (@(posedge clk) disable iff (rst)
    (!jump && (br_kind == 2'b00 || br_kind == 2'b11)) |=> pc == $past(pc) + WIDTH'(1)); // R2
  AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(pc_next)); // R8
endmodule

// File: tb/skip_pc_unit_test.sv
module skip_pc_unit_test;
  logic clk = 0, rst = 1, jump = 0;
  logic [1:0] br_kind = 0;
  logic [31:0] reg_val = 0;
  logic [15:0] imm = 0;
  logic [31:0] pc, pc_next;
  int total = 0, bad = 0;
  bit done = 0;

  skip_pc_unit uut (.clk(clk), .rst(rst), .br_kind(br_kind), .jump(jump),
    .reg_val(reg_val), .imm(imm), .pc(pc), .pc_next(pc_next));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_pc(input logic [31:0] v);
    jump = 1; reg_val = v; br_kind = 0;
    @(posedge clk); #1;
    jump = 0;
  endtask

  task automatic step(input string req, input logic [1:0] k, input logic j,
                      input logic [31:0] rv, input logic [15:0] im);
    logic [31:0] start, exp;
    logic eq;
    start = pc;
    br_kind = k; jump = j; reg_val = rv; imm = im;
    eq = (rv == {16'h0, im});
    if (j) exp = rv;
    else if ((k == 2'b01 && eq) || (k == 2'b10 && !eq)) exp = start + 2;
    else exp = start + 1;
    #1 chk({req, " R8"}, pc_next, exp);
    @(posedge clk); #1;
    chk(req, pc, exp);
    jump = 0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 chk("R1", pc, 0);
    rst = 0;
    for (int k = 0; k < 4; k++)
      for (int e = 0; e < 2; e++) begin
        step(k == 1 ? "R3" : k == 2 ? "R4" : "R2", 2'(k), 0,
             e ? 32'h0000_1234 : 32'h0000_1235, 16'h1234);
        step("R5", 2'(k), 1, 32'h100 * (k + 1) + e, 16'h0);
      end
    for (int v = 0; v < 4; v++)
      for (int m = 0; m < 4; m++) begin
        step("R3", 2'b01, 0, 32'(v), 16'(m));
        step("R4", 2'b10, 0, 32'(v), 16'(m));
      end
    step("R6", 2'b01, 0, 32'h0001_0005, 16'h0005);
    step("R6", 2'b10, 0, 32'h8000_0005, 16'h0005);
    step("R6", 2'b01, 0, 32'h0000_FFFF, 16'hFFFF);
    set_pc(32'hFFFF_FFFF);
    step("R7", 2'b01, 0, 32'h7, 16'h7);
    chk("R7", pc, 32'h1);
    set_pc(32'hFFFF_FFFE);
    step("R7", 2'b10, 0, 32'h7, 16'h7);
    step("R7", 2'b00, 0, 32'h0, 16'h0);
    chk("R7", pc, 32'h0);
    set_pc(32'hFFFF_FFFE);
    step("R7", 2'b10, 0, 32'h1, 16'h2);
    step("R7", 2'b11, 0, 32'h5, 16'h5);
    rst = 1; @(posedge clk); #1;
    chk("R1", pc, 0);
    rst = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule